// File: doc/BRIEF.md
# Configurable Countdown Timer

This block is a programmable down-counting timer meant to pace an attached serial shifter. It drives a timer output, a shift clock derived from that output or from its own decrement activity, and a sticky status flag that marks compare events. A compare register supplies the reload value. A control register selects the mode, the decrement source, the reload (reset) source, the initial output level, whether a reload also updates the output, and where the shift clock comes from.

Two modes exist. In full-width count mode the whole counter runs down and wraps, and each wrap flips the output. In split-byte PWM mode the low byte times the high phase of the output and the high byte times the low phase. Each byte reloads from its own half of the compare register. The decrement source can be every clock, every clock gated by the trigger level, or both edges of the external pin or trigger. Both external inputs pass through a two-flop synchroniser before any edge is detected.

Top module: `mmtimer`

## Requirements
- R1: After synchronous reset, tmr_out, sclk_out and flag are 0 and the control mode is off. While the mode field (control bits [1:0]) is 00 or 11, the output and counter hold their values whatever the decrement source.
- R2: A control write (wr_addr=1) that moves the mode from off to active loads the counter from the compare register (wr_addr=0) one cycle after the write. In count mode (01) the output then takes the initial level given by control bit 6. In PWM mode (10) the output starts high and bit 6 is ignored.
- R3: The output initialisation at enable never changes sclk_out, so it cannot produce a shift-clock edge.
- R4: In count mode, a decrement while the counter is zero flips tmr_out and reloads the compare value. With every-clock decrement, the first flip comes C+2 cycles after the enabling write, and later flips follow every C+1 cycles, where C is the compare value.
- R5: A compare event sets flag. The flag then stays set until a flag_clr pulse. When a clear and an event fall in the same cycle, the flag stays set.
- R6: In PWM mode the output stays high for L+1 decrements and low for H+1 decrements, where L is compare[7:0] and H is compare[15:8].
- R7: In PWM mode, the flag is set only when the low phase ends, and only for decrement select (control bits [3:2]) 00 or 01. With select 10 or 11 the flag is never set.
- R8: Decrement select 10 counts both edges of pin_in, and 11 counts both edges of trig_in. The counter acts two cycles after the first clock edge that samples the new input level.
- R9: Decrement select 00 decrements every clock. Select 01 decrements only on cycles where the synchronised trig_in is high.
- R10: Reload select (control bits [5:4]) works as follows: 00 none, 01 pin_in rising edge, 10 trig_in rising edge, 11 pin_in high level. A reload restores the compare value. When control bit 7 is set, a reload also returns the output to its start level (and sclk_out follows in output-clock mode). When bit 7 is clear, the output is untouched.
- R11: With control bit 8 clear, sclk_out takes each new output value produced by a decrement or reload. With bit 8 set, sclk_out toggles on every decrement.
- R12: A compare write while running changes nothing until the next reload, and that reload uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects compare, 1 selects control |
| wr_data | input | CNT_W | Write data |
| pin_in | input | 1 | External pin, asynchronous |
| trig_in | input | 1 | External trigger, asynchronous |
| flag_clr | input | 1 | Write-one-to-clear pulse for the status flag |
| tmr_out | output | 1 | Timer output |
| sclk_out | output | 1 | Shift clock for the attached shifter |
| flag | output | 1 | Sticky compare-event flag |

## Verification
Most internal faults show up at the next wrap. A counter loaded with the wrong value, or a byte reloaded from the wrong half, moves the next output transition by whole decrement periods, so the checks sample the cycle just before and just at each predicted flip. A shift clock that tracks the enable-time output instead of real transitions rises one cycle after enable rather than at the second flip. A lost flag update appears at the very cycle of the event or the clear. Synchroniser depth errors move pin-driven and trigger-driven activity by a cycle, which the edge-latency checks catch at once.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_CNT = 2'b01,
      MODE_PWM = 2'b10,
      MODE_RSV = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      DEC_CLK   = 2'b00,
      DEC_GATED = 2'b01,
      DEC_PIN   = 2'b10,
      DEC_TRIG  = 2'b11
   } dec_e;

   typedef enum logic [1:0] {
      RLD_NONE      = 2'b00,
      RLD_PIN_RISE  = 2'b01,
      RLD_TRIG_RISE = 2'b10,
      RLD_PIN_HIGH  = 2'b11
   } rld_e;

   // control register layout, LSB at the bottom
   typedef struct packed {
      logic  sclk_dec;   // [8] shift clock toggles per decrement
      logic  rld_upd;    // [7] reload also updates output
      logic  init_hi;    // [6] count-mode start level
      rld_e  rld_sel;    // [5:4]
      dec_e  dec_sel;    // [3:2]
      mode_e mode;       // [1:0]
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
   localparam int N_EXT  = 2;
   localparam int EXT_PIN = 0;
   localparam int EXT_TRG = 1;

   function automatic logic mode_active(mode_e m);
      return (m == MODE_CNT) || (m == MODE_PWM);
   endfunction

endpackage

// File: rtl/mmt_sync_edge.sv
module mmt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mmt_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;

endmodule

// File: rtl/mmt_regs.sv
module mmt_regs
   import mmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cmp_q,
   output ctrl_t            ctrl_q,
   output logic             start_q
);

   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("mmt_regs: CNT_W too narrow for the control word");
   end

   ctrl_t ctrl_new;
   logic  wr_ctrl;
   logic  wr_cmp;

   assign ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);
   assign wr_ctrl  = wr_en & wr_addr;
   assign wr_cmp   = wr_en & ~wr_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmp_q   <= '0;
         ctrl_q  <= '0;
         start_q <= 1'b0;
      end else begin
         if (wr_cmp) cmp_q <= wr_data;
         if (wr_ctrl) ctrl_q <= ctrl_new;
         start_q <= wr_ctrl & mode_active(ctrl_new.mode) & ~mode_active(ctrl_q.mode);
      end
   end

   // R2
   start_follows_enable_chk: assert property (@(posedge clk) disable iff (rst)
      start_q |-> mode_active(ctrl_q.mode));

endmodule

// File: rtl/mmt_core.sv
module mmt_core
   import mmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cmp,
   input  ctrl_t            ctrl,
   input  logic             start,
   input  logic [N_EXT-1:0] ext_lvl,
   input  logic [N_EXT-1:0] ext_rise,
   input  logic [N_EXT-1:0] ext_fall,
   input  logic             flag_clr,
   output logic             tmr_out,
   output logic             sclk,
   output logic             flag
);

   localparam int HALF = CNT_W / 2;
   localparam logic [CNT_W-1:0] ONE_F = 1;
   localparam logic [HALF-1:0]  ONE_H = 1;

   logic [CNT_W-1:0] cnt, cnt_d;
   logic [HALF-1:0]  lo, hi;
   logic             out_d, sclk_d, flag_d, hit;
   logic             active, is_pwm, dec_evt, rld_evt, init_lvl;

   assign lo       = cnt[HALF-1:0];
   assign hi       = cnt[CNT_W-1:HALF];
   assign active   = mode_active(ctrl.mode);
   assign is_pwm   = (ctrl.mode == MODE_PWM);
   assign init_lvl = is_pwm ? 1'b1 : ctrl.init_hi;

   always_comb begin
      case (ctrl.dec_sel)
         DEC_CLK:   dec_evt = 1'b1;
         DEC_GATED: dec_evt = ext_lvl[EXT_TRG];
         DEC_PIN:   dec_evt = ext_rise[EXT_PIN] | ext_fall[EXT_PIN];
         default:   dec_evt = ext_rise[EXT_TRG] | ext_fall[EXT_TRG];
      endcase
   end

   always_comb begin
      case (ctrl.rld_sel)
         RLD_NONE:      rld_evt = 1'b0;
         RLD_PIN_RISE:  rld_evt = ext_rise[EXT_PIN];
         RLD_TRIG_RISE: rld_evt = ext_rise[EXT_TRG];
         default:       rld_evt = ext_lvl[EXT_PIN];
      endcase
   end

   always_comb begin
      cnt_d  = cnt;
      out_d  = tmr_out;
      sclk_d = sclk;
      hit    = 1'b0;
      if (active) begin
         if (start) begin
            cnt_d = cmp;
            out_d = init_lvl;
         end else if (rld_evt) begin
            cnt_d = cmp;
            if (ctrl.rld_upd) begin
               out_d = init_lvl;
               if (!ctrl.sclk_dec) sclk_d = init_lvl;
            end
         end else if (dec_evt) begin
            if (is_pwm) begin
               if (tmr_out) begin
                  if (lo == '0) begin
                     out_d            = 1'b0;
                     cnt_d[HALF-1:0] = cmp[HALF-1:0];
                  end else begin
                     cnt_d[HALF-1:0] = lo - ONE_H;
                  end
               end else begin
                  if (hi == '0) begin
                     out_d               = 1'b1;
                     cnt_d[CNT_W-1:HALF] = cmp[CNT_W-1:HALF];
                     hit                 = ~ctrl.dec_sel[1];
                  end else begin
                     cnt_d[CNT_W-1:HALF] = hi - ONE_H;
                  end
               end
            end else begin
               if (cnt == '0) begin
                  cnt_d = cmp;
                  out_d = ~tmr_out;
                  hit   = 1'b1;
               end else begin
                  cnt_d = cnt - ONE_F;
               end
            end
            if (ctrl.sclk_dec) sclk_d = ~sclk;
            else if (out_d != tmr_out) sclk_d = out_d;
         end
      end
   end

   assign flag_d = hit | (flag & ~flag_clr);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         tmr_out <= 1'b0;
         sclk    <= 1'b0;
         flag    <= 1'b0;
      end else begin
         cnt     <= cnt_d;
         tmr_out <= out_d;
         sclk    <= sclk_d;
         flag    <= flag_d;
      end
   end

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !active |=> $stable(tmr_out) && $stable(cnt));

   // R2
   pwm_starts_high_chk: assert property (@(posedge clk) disable iff (rst)
      start && is_pwm |=> tmr_out);

   // R3
   init_no_sclk_edge_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> $stable(sclk));

   // R4
   wrap_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl.mode == MODE_CNT) && !start && !rld_evt && dec_evt && (cnt == '0)
      |=> (tmr_out != $past(tmr_out)) && (cnt == $past(cmp)));

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      flag && !flag_clr |=> flag);

   // R6
   low_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      is_pwm && !tmr_out && !start && !rld_evt && dec_evt && (hi != '0) |=> !tmr_out);

   // R6
   high_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      is_pwm && tmr_out && !start && !rld_evt && dec_evt && (lo != '0) |=> tmr_out);

   // R7
   pwm_edge_src_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
      is_pwm && ctrl.dec_sel[1] && !flag |=> !flag);

   // R10
   reload_value_chk: assert property (@(posedge clk) disable iff (rst)
      active && rld_evt && !start |=> cnt == $past(cmp));

   // R11
   sclk_per_dec_chk: assert property (@(posedge clk) disable iff (rst)
      active && ctrl.sclk_dec && dec_evt && !start && !rld_evt |=> sclk != $past(sclk));

endmodule

// File: rtl/mmtimer.sv
module mmtimer
   import mmt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             pin_in,
   input  logic             trig_in,
   input  logic             flag_clr,
   output logic             tmr_out,
   output logic             sclk_out,
   output logic             flag
);

   if ((CNT_W % 2) != 0 || CNT_W < 4) begin : g_bad_cnt
      $error("mmtimer: CNT_W must be even and at least 4");
   end

   logic [N_EXT-1:0] ext_raw;
   logic [N_EXT-1:0] ext_lvl, ext_rise, ext_fall;
   logic [CNT_W-1:0] cmp_q;
   ctrl_t            ctrl_q;
   logic             start_q;

   assign ext_raw[EXT_PIN] = pin_in;
   assign ext_raw[EXT_TRG] = trig_in;

   for (genvar i = 0; i < N_EXT; i++) begin : g_ext
      mmt_sync_edge #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk   (clk),
         .rst   (rst),
         .din   (ext_raw[i]),
         .level (ext_lvl[i]),
         .rise  (ext_rise[i]),
         .fall  (ext_fall[i])
      );
   end

   mmt_regs #(
      .CNT_W (CNT_W)
   ) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cmp_q   (cmp_q),
      .ctrl_q  (ctrl_q),
      .start_q (start_q)
   );

   mmt_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk      (clk),
      .rst      (rst),
      .cmp      (cmp_q),
      .ctrl     (ctrl_q),
      .start    (start_q),
      .ext_lvl  (ext_lvl),
      .ext_rise (ext_rise),
      .ext_fall (ext_fall),
      .flag_clr (flag_clr),
      .tmr_out  (tmr_out),
      .sclk     (sclk_out),
      .flag     (flag)
   );

endmodule

// File: tb/sim_mmtimer.sv
`timescale 1ns/1ps
module sim_mmtimer;

   localparam int S_OUT  = 0;
   localparam int S_SCLK = 1;
   localparam int S_FLAG = 2;

   typedef struct {
      int    cyc;
      int    sig;
      logic  val;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        pin_in = 1'b0;
   logic        trig_in = 1'b0;
   logic        flag_clr = 1'b0;
   logic        tmr_out, sclk_out, flag;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   mmtimer u0 (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pin_in   (pin_in),
      .trig_in  (trig_in),
      .flag_clr (flag_clr),
      .tmr_out  (tmr_out),
      .sclk_out (sclk_out),
      .flag     (flag)
   );

   // monitor: pops expected items as their cycle arrives
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t it;
         logic act;
         it = q.pop_front();
         case (it.sig)
            S_OUT:   act = tmr_out;
            S_SCLK:  act = sclk_out;
            default: act = flag;
         endcase
         checks++;
         if (it.cyc != cyc || act !== it.val) begin
            errors++;
            $display("FAIL %s: sig %0d cycle %0d (now %0d) actual %b expected %b",
                     it.tag, it.sig, it.cyc, cyc, act, it.val);
         end
      end
   end

   task automatic push(input int c, input int s, input logic v, input string t);
      exp_t it;
      int   k;
      it.cyc = c; it.sig = s; it.val = v; it.tag = t;
      k = 0;
      while (k < q.size() && q[k].cyc <= c) k++;
      q.insert(k, it);
   endtask

   task automatic do_reset(output int c0);
      @(negedge clk);
      rst = 1'b1; pin_in = 1'b0; trig_in = 1'b0;
      wr_en = 1'b0; flag_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      c0 = cyc;
   endtask

   task automatic wr(input logic a, input logic [15:0] d, output int w);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      w = cyc;
   endtask

   // return at the negedge just before edge e
   task automatic tick_to(input int e);
      while (cyc < e - 1) @(negedge clk);
   endtask

   task automatic settle(input int e);
      while (cyc < e) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int c0, w, wx;

      // ---- reset state and idle mode (R1)
      do_reset(c0);
      push(c0 + 1, S_OUT,  1'b0, "R1");
      push(c0 + 1, S_SCLK, 1'b0, "R1");
      push(c0 + 1, S_FLAG, 1'b0, "R1");
      wr(1'b0, 16'h0000, wx);
      wr(1'b1, 16'h0003, w);          // mode 11: stays off
      push(w + 2, S_OUT,  1'b0, "R1");
      push(w + 3, S_OUT,  1'b0, "R1");
      push(w + 3, S_FLAG, 1'b0, "R1");
      settle(w + 3);

      // ---- count mode, every clock, init high, C=3 (R2 R3 R4 R5 R11 R12)
      do_reset(c0);
      wr(1'b0, 16'd3, wx);
      wr(1'b1, 16'h0041, w);
      push(w + 1, S_OUT,  1'b1, "R2");
      push(w + 1, S_SCLK, 1'b0, "R3");
      push(w + 4, S_OUT,  1'b1, "R4");
      push(w + 5, S_OUT,  1'b0, "R4");
      push(w + 5, S_FLAG, 1'b1, "R5");
      push(w + 5, S_SCLK, 1'b0, "R3");
      push(w + 8, S_OUT,  1'b0, "R4");
      push(w + 9, S_OUT,  1'b1, "R4");
      push(w + 9, S_SCLK, 1'b1, "R11");
      push(w + 10, S_FLAG, 1'b0, "R5");
      push(w + 12, S_FLAG, 1'b0, "R5");
      push(w + 13, S_FLAG, 1'b1, "R5");
      push(w + 17, S_FLAG, 1'b1, "R5");
      push(w + 18, S_FLAG, 1'b1, "R5");
      push(w + 20, S_OUT,  1'b1, "R12");
      push(w + 21, S_OUT,  1'b0, "R12");
      push(w + 26, S_OUT,  1'b0, "R12");
      push(w + 27, S_OUT,  1'b1, "R12");
      tick_to(w + 10); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      tick_to(w + 17); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      tick_to(w + 19); wr(1'b0, 16'd5, wx);
      settle(w + 27);

      // ---- PWM mode, every clock, L=1 H=2 (R2 R3 R6 R7)
      do_reset(c0);
      wr(1'b0, 16'h0201, wx);
      wr(1'b1, 16'h0002, w);
      push(w + 1, S_OUT,  1'b1, "R2");
      push(w + 1, S_SCLK, 1'b0, "R3");
      push(w + 2, S_OUT,  1'b1, "R6");
      push(w + 3, S_OUT,  1'b0, "R6");
      push(w + 3, S_FLAG, 1'b0, "R7");
      push(w + 5, S_OUT,  1'b0, "R6");
      push(w + 6, S_OUT,  1'b1, "R6");
      push(w + 6, S_FLAG, 1'b1, "R7");
      push(w + 6, S_SCLK, 1'b1, "R11");
      push(w + 8, S_OUT,  1'b0, "R6");
      push(w + 11, S_OUT, 1'b1, "R6");
      settle(w + 11);

      // ---- PWM mode, pin both edges, C=0 (R7 R8)
      do_reset(c0);
      wr(1'b0, 16'h0000, wx);
      wr(1'b1, 16'h000A, w);
      push(w + 1,  S_OUT,  1'b1, "R2");
      push(w + 4,  S_OUT,  1'b1, "R8");
      push(w + 5,  S_OUT,  1'b0, "R8");
      push(w + 9,  S_OUT,  1'b0, "R8");
      push(w + 10, S_OUT,  1'b1, "R8");
      push(w + 12, S_FLAG, 1'b0, "R7");
      tick_to(w + 3); pin_in = 1'b1;
      tick_to(w + 8); pin_in = 1'b0;
      settle(w + 12);

      // ---- count mode, trigger both edges, shift clock per decrement, C=1 (R8 R11 R3)
      do_reset(c0);
      wr(1'b0, 16'd1, wx);
      wr(1'b1, 16'h010D, w);
      push(w + 1, S_OUT,  1'b0, "R2");
      push(w + 1, S_SCLK, 1'b0, "R3");
      push(w + 4, S_SCLK, 1'b0, "R8");
      push(w + 5, S_SCLK, 1'b1, "R11");
      push(w + 5, S_OUT,  1'b0, "R8");
      push(w + 9, S_OUT,  1'b1, "R8");
      push(w + 9, S_SCLK, 1'b0, "R11");
      push(w + 9, S_FLAG, 1'b1, "R5");
      tick_to(w + 3); trig_in = 1'b1;
      tick_to(w + 7); trig_in = 1'b0;
      settle(w + 9);

      // ---- count mode, clock gated by trigger, C=2 (R9)
      do_reset(c0);
      wr(1'b0, 16'd2, wx);
      wr(1'b1, 16'h0005, w);
      push(w + 10, S_OUT,  1'b0, "R9");
      push(w + 13, S_OUT,  1'b0, "R9");
      push(w + 14, S_OUT,  1'b1, "R9");
      push(w + 20, S_OUT,  1'b1, "R9");
      tick_to(w + 10); trig_in = 1'b1;
      tick_to(w + 15); trig_in = 1'b0;
      settle(w + 20);

      // ---- reload on pin rise, output updated (R10)
      do_reset(c0);
      wr(1'b0, 16'd3, wx);
      wr(1'b1, 16'h0091, w);
      push(w + 7,  S_OUT,  1'b1, "R10");
      push(w + 7,  S_SCLK, 1'b1, "R10");
      push(w + 8,  S_OUT,  1'b0, "R10");
      push(w + 8,  S_SCLK, 1'b0, "R10");
      push(w + 11, S_OUT,  1'b0, "R10");
      push(w + 12, S_OUT,  1'b1, "R10");
      tick_to(w + 6); pin_in = 1'b1;
      settle(w + 12);

      // ---- reload on pin rise, output untouched (R10)
      do_reset(c0);
      wr(1'b0, 16'd3, wx);
      wr(1'b1, 16'h0011, w);
      push(w + 8,  S_OUT, 1'b1, "R10");
      push(w + 11, S_OUT, 1'b1, "R10");
      push(w + 12, S_OUT, 1'b0, "R10");
      tick_to(w + 6); pin_in = 1'b1;
      settle(w + 12);

      done = 1'b1;
      if (q.size() != 0) begin
         errors++;
         checks++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule